// File: doc/BRIEF.md
# Registered-Handshake Elastic Pipeline Link

This block cuts a long single-lane point-to-point link into shorter timing segments. The sender drives `src_data` with `src_valid`, and the receiver answers with `dst_ready`. The block places a configurable number of identical stages between the two ends. Each stage registers every signal it drives: data and valid going forward, and ready going back. No combinational path crosses a stage in either direction.

A single register whose ready is registered can only take a word every other cycle. Each stage therefore pairs two such half-rate slots. The primary slot feeds the stage output. The spare slot catches the word that was already committed when the downstream side stopped. The stage withdraws its ready only once both slots hold data. When the stall clears, the primary slot drains first and the spare word moves into it, so the pair keeps one word per cycle and the original order. A word handed over at the input reaches the output after one cycle per stage when the link is empty. Under a permanent stall the link holds two words per stage.

Top module: `elb_link`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `src_ready` is 1 and `dst_valid` is 0 (both slots of every stage are empty).
- R2: Every word accepted at the input (`src_valid` and `src_ready` both 1 at a rising edge) is delivered exactly once at the output (`dst_valid` and `dst_ready` both 1), in acceptance order, under any pattern of `src_valid` and `dst_ready`.
- R3: With `dst_ready` held at 1 and `src_valid` held at 1 from an empty link, `src_ready` stays 1, so a word is accepted every cycle. After the first STAGES cycles, a word is also delivered every cycle.
- R4: In an empty link, a word accepted at one rising edge makes `dst_valid` rise exactly STAGES rising edges later, so it is visible STAGES cycles after acceptance.
- R5: With `dst_ready` held at 0 and `src_valid` held at 1 from an empty link, exactly 2*STAGES words are accepted, and then `src_ready` stays 0.
- R6: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid` stays 1 and `dst_data` stays unchanged in the next cycle.
- R7: `src_ready` falls only after a cycle in which the first stage held an output word that was not taken. Changing `src_valid`, `src_data` or `dst_ready` within a cycle never changes `src_ready` or `dst_valid` in that same cycle.
- R8: After a link filled to capacity is released (`dst_ready` set to 1, `src_valid` 0), its 2*STAGES words are delivered on 2*STAGES consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | WIDTH | Word offered by the sender |
| src_valid | input | 1 | Sender offers a word |
| src_ready | output | 1 | Link can take a word (registered) |
| dst_data | output | WIDTH | Word offered to the receiver (registered) |
| dst_valid | output | 1 | Link offers a word (registered) |
| dst_ready | input | 1 | Receiver takes the offered word |

## Verification
The hardest state to reach from the ports is a stall release where every stage is full at once. In that state each primary slot swaps in its spare word while the upstream stage pushes a new one behind it. Only then are the spare-slot paths exercised in every stage in the same cycle. The stimulus reaches it by holding `dst_ready` low with the input saturated until `src_ready` drops. It then releases and counts back-to-back deliveries. A long random phase with independently biased valid and ready then mixes partial fills and releases, and a queue-based scoreboard checks every delivered word.

// File: rtl/elb_pkg.sv
package elb_pkg;
  // number of half-rate slots inside one stage (primary plus spare)
  localparam int unsigned SLOTS_PER_STAGE = 2;

  function automatic int unsigned link_capacity(input int unsigned stages);
    return stages * SLOTS_PER_STAGE;
  endfunction
endpackage

// File: rtl/elb_slot.sv
// One half-rate storage slot: a data register with an occupancy flag.
module elb_slot #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  always_ff @(posedge clk) begin
    if (rst)        full <= 1'b0;
    else if (load)  full <= 1'b1;
    else if (clear) full <= 1'b0;
  end
endmodule

// File: rtl/elb_stage.sv
// One full-rate stage built from a primary and a spare half-rate slot.
module elb_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  logic [WIDTH-1:0] pri_q, spr_q, pri_d;
  logic pri_full, spr_full;
  logic pri_free, take;
  logic pri_load, pri_clear, spr_load, spr_clear, spr_next;
  logic ready_q;

  assign take      = in_valid & ready_q;
  assign pri_free  = ~pri_full | out_ready;
  assign pri_load  = pri_free & (spr_full | take);
  assign pri_clear = pri_free & ~spr_full & ~take;
  assign pri_d     = spr_full ? spr_q : in_data;
  assign spr_load  = ~pri_free & take;
  assign spr_clear = pri_free & spr_full;
  assign spr_next  = spr_load | (spr_full & ~spr_clear);

  elb_slot #(.WIDTH(WIDTH)) u_pri (
    .clk(clk), .rst(rst), .load(pri_load), .clear(pri_clear),
    .d(pri_d), .q(pri_q), .full(pri_full)
  );

  elb_slot #(.WIDTH(WIDTH)) u_spr (
    .clk(clk), .rst(rst), .load(spr_load), .clear(spr_clear),
    .d(in_data), .q(spr_q), .full(spr_full)
  );

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b1;
    else     ready_q <= ~spr_next;
  end

  assign in_ready  = ready_q;
  assign out_data  = pri_q;
  assign out_valid = pri_full;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pri_full && !out_ready) |=> (pri_full && $stable(pri_q)));

  // R7
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_q) |-> $past(pri_full && !out_ready));

  // R2
  spare_order_chk: assert property (@(posedge clk) disable iff (rst)
    spr_full |-> pri_full);

  // R2
  spare_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (spr_full && !out_ready) |=> (spr_full && $stable(spr_q)));

  // R4
  accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> pri_full);
endmodule

// File: rtl/elb_link.sv
// Chain of STAGES registered elastic stages forming a pipelined link.
module elb_link
  import elb_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src_data,
  input  logic             src_valid,
  output logic             src_ready,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_valid,
  input  logic             dst_ready
);
  localparam int unsigned CAPACITY = link_capacity(STAGES);
  localparam int unsigned CW       = $clog2(CAPACITY + 2);

  logic [WIDTH-1:0] seg_data  [STAGES+1];
  logic             seg_valid [STAGES+1];
  logic             seg_ready [STAGES+1];

  assign seg_data[0]       = src_data;
  assign seg_valid[0]      = src_valid;
  assign src_ready         = seg_ready[0];
  assign dst_data          = seg_data[STAGES];
  assign dst_valid         = seg_valid[STAGES];
  assign seg_ready[STAGES] = dst_ready;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    elb_stage #(.WIDTH(WIDTH)) u_stage (
      .clk(clk), .rst(rst),
      .in_data(seg_data[i]), .in_valid(seg_valid[i]), .in_ready(seg_ready[i]),
      .out_data(seg_data[i+1]), .out_valid(seg_valid[i+1]),
      .out_ready(seg_ready[i+1])
    );
  end

  // occupancy tracking used only by the checks below
  logic [CW-1:0] held;
  logic          in_hs, out_hs;
  assign in_hs  = src_valid & src_ready;
  assign out_hs = dst_valid & dst_ready;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= held + CW'(in_hs) - CW'(out_hs);
  end

  // R5
  capacity_chk: assert property (@(posedge clk) disable iff (rst)
    held <= CW'(CAPACITY));

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (held == CW'(CAPACITY)) |-> !src_ready);

  // R2
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    (held == '0) |-> !dst_valid);
endmodule

// File: tb/sim_elb_link.sv
`timescale 1ns/1ps
module sim_elb_link;
  localparam int W = 16;
  localparam int S = 3;
  localparam int CAP = 2 * S;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] src_data = '0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [W-1:0] dst_data;
  logic dst_valid;
  logic dst_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int in_cnt = 0;
  int out_cnt = 0;
  logic [W-1:0] seq = '0;
  logic [W-1:0] sb [$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  elb_link #(.WIDTH(W), .STAGES(S)) u0 (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .dst_data(dst_data), .dst_valid(dst_valid),
    .dst_ready(dst_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus; pushes accepted words into the scoreboard
  task automatic step(input bit v, input bit r);
    @(negedge clk);
    src_valid = v;
    dst_ready = r;
    src_data  = seq;
    #1;
    if (src_valid && src_ready) begin
      sb.push_back(src_data);
      seq = seq + 1'b1;
      in_cnt++;
    end
  endtask

  // monitor: pops and compares every delivered word (R2)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && dst_valid && dst_ready) begin
        out_cnt++;
        if (sb.size() == 0) check(1'b0, "R2 extra word", int'(dst_data), -1);
        else begin
          logic [W-1:0] e;
          e = sb.pop_front();
          check(dst_data == e, "R2 order", int'(dst_data), int'(e));
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base_in, base_out, lat;
    logic [W-1:0] held_word;
    bit drained_ok;
    @(negedge clk);
    #1;
    check(src_ready == 1'b1, "R1 ready in reset", src_ready, 1);
    check(dst_valid == 1'b0, "R1 valid in reset", dst_valid, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check(src_ready == 1'b1 && dst_valid == 1'b0, "R1 after reset",
          {src_ready, dst_valid}, 2);

    // R4 latency from empty link
    step(1'b1, 1'b1);
    lat = 0;
    for (int k = 1; k <= S + 2; k++) begin
      step(1'b0, 1'b1);
      if (dst_valid && lat == 0) lat = k;
    end
    check(lat == S, "R4 latency", lat, S);

    // R3 full throughput
    base_in = in_cnt;
    base_out = out_cnt;
    for (int k = 0; k < 40; k++) begin
      step(1'b1, 1'b1);
      if (!src_ready) check(1'b0, "R3 ready dropped", 0, 1);
    end
    #2;
    check(in_cnt - base_in == 40, "R3 accepts", in_cnt - base_in, 40);
    check(out_cnt - base_out == 40 - S, "R3 deliveries", out_cnt - base_out, 40 - S);
    for (int k = 0; k < 2 * S + 2; k++) step(1'b0, 1'b1);
    check(sb.size() == 0, "R2 drained", sb.size(), 0);

    // R5 capacity under permanent stall, R6 hold
    base_in = in_cnt;
    held_word = '0;
    for (int k = 0; k < 3 * S + 4; k++) begin
      step(1'b1, 1'b0);
      if (k == S) held_word = dst_data;
      if (k > S) begin
        if (!dst_valid || dst_data != held_word)
          check(1'b0, "R6 hold", int'(dst_data), int'(held_word));
      end
    end
    check(in_cnt - base_in == CAP, "R5 capacity", in_cnt - base_in, CAP);
    check(src_ready == 1'b0, "R5 blocked", src_ready, 0);
    check(dst_valid == 1'b1 && dst_data == held_word, "R6 final hold",
          int'(dst_data), int'(held_word));

    // R7 same-cycle independence of registered outputs
    @(negedge clk);
    src_valid = 1'b0; dst_ready = 1'b1; #0.5;
    src_valid = 1'b1; dst_ready = 1'b0; #0.5;
    check(src_ready == 1'b0 && dst_valid == 1'b1, "R7 registered outputs",
          {src_ready, dst_valid}, 1);
    dst_ready = 1'b0; src_valid = 1'b0;

    // R8 back-to-back drain from full
    base_out = out_cnt;
    drained_ok = 1'b1;
    for (int k = 0; k < CAP; k++) begin
      step(1'b0, 1'b1);
      if (!dst_valid) drained_ok = 1'b0;
    end
    #2;
    check(drained_ok && out_cnt - base_out == CAP, "R8 drain",
          out_cnt - base_out, CAP);
    step(1'b0, 1'b1);
    check(dst_valid == 1'b0, "R8 empty after drain", dst_valid, 0);

    // R2 random stall patterns
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 4) != 0, ($urandom % 3) != 0);
    end
    for (int k = 0; k < 4 * S + 4; k++) step(1'b0, 1'b1);
    check(sb.size() == 0, "R2 nothing lost", sb.size(), 0);
    check(in_cnt == out_cnt, "R2 counts match", out_cnt, in_cnt);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule